// File: doc/BRIEF.md
# Single-Operand Bit Manipulation Unit

This unit takes one 32-bit register value and a 4-bit sub-opcode and produces a transformed value together with a carry flag. It covers leading-one search, bit mirroring, byte extraction, byte and halfword extension, decrement with a signed test, a test that all bytes are nonzero, absolute value and bitwise inversion.

A surrounding execute stage presents the operand, the sub-opcode and the present carry with a one-cycle strobe. Exactly one cycle later the unit returns the result and a destination flag. The flag tells the write-back logic whether the result goes to the operand's own register or to the fixed register that receives extracted bytes. The unit also returns a carry-write enable and the carry value to use. Instruction fetch, the register file and exceptions are handled elsewhere.

Top module: `bitu_unit`

## Requirements
- R1: Sub-opcode encoding: 0..3 extract a byte lane, 4 zero-extends a byte, 5 sign-extends a byte, 6 zero-extends a halfword, 7 sign-extends a halfword, 8 decrement-test-negative, 9 all-bytes-nonzero test, 10 decrement-test-positive, 11 decrement-test-nonzero, 12 leading-one count, 13 bit reversal, 14 absolute value, 15 bitwise NOT. `out_dst_ext` is 1 only for codes 0..3.
- R2: Extraction code k (0..3) returns operand bits [8k+7:8k], zero-extended. Carry is written with 1 when the whole operand is nonzero and with 0 otherwise.
- R3: Zero extension keeps bits [7:0] or [15:0] and clears the rest. Sign extension copies bit 7 or bit 15 into all higher bits. Carry is not written.
- R4: The three decrement codes return operand minus 1, wrapping modulo 2^32. Carry is written with the signed test of that result: below zero (code 8), above zero (code 10) or not zero (code 11).
- R5: The all-bytes-nonzero test returns the operand unchanged. It writes carry with 1 only when each of the four bytes is nonzero.
- R6: The leading-one count returns the number of zero bits above the highest set bit, counting down from bit 31. It returns 32 for a zero operand and does not write carry.
- R7: Bit reversal swaps bit i with bit 31-i for every i and does not write carry.
- R8: Absolute value returns the two's complement of the operand when bit 31 is set and the operand itself otherwise, so 0x80000000 maps to itself. NOT inverts every bit. Neither writes carry.
- R9: When a code does not write carry, `out_cwe` is 0 and `out_carry` equals the `in_carry` presented with the strobe.
- R10: The outputs for a strobed input appear on the cycle after it with `out_vld` high. In a cycle following no strobe, `out_vld` and `out_cwe` are 0 and `out_res` holds its value.
- R11: Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Strobe: operand and sub-opcode are valid |
| in_op | input | 4 | Sub-opcode (see R1) |
| in_opnd | input | 32 | Operand value |
| in_carry | input | 1 | Current carry flag |
| out_vld | output | 1 | Registered result valid |
| out_res | output | 32 | Registered result |
| out_dst_ext | output | 1 | 1: write to the fixed extract register; 0: write to the operand register |
| out_cwe | output | 1 | Carry-write enable |
| out_carry | output | 1 | Carry value to use |

## Verification
The sweep feeds every sub-opcode with both carry inputs and a fixed set of edge operands: zero, all ones, the two 32-bit sign extremes, single set bits and values with exactly one zero byte. A set of pseudo-random values is added to these. A leading-one counter with an off-by-one error, or one that returns 31 for zero, shows up on the single-bit and zero operands. A byte lane taken in the wrong order fails on the distinct-byte patterns. Decrement tests that compare the operand instead of the result fail at 1 and at 0x80000000. Absolute value is probed at the most negative number. Idle cycles between strobes catch a unit that keeps `out_cwe` high or lets a stale carry through.

// File: rtl/bitu_pkg.sv
package bitu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_XB0   = 4'h0,
    OP_XB1   = 4'h1,
    OP_XB2   = 4'h2,
    OP_XB3   = 4'h3,
    OP_ZXB   = 4'h4,
    OP_SXB   = 4'h5,
    OP_ZXH   = 4'h6,
    OP_SXH   = 4'h7,
    OP_DECLT = 4'h8,
    OP_ALLNZ = 4'h9,
    OP_DECGT = 4'hA,
    OP_DECNE = 4'hB,
    OP_LEAD1 = 4'hC,
    OP_REV   = 4'hD,
    OP_ABS   = 4'hE,
    OP_NOT   = 4'hF
  } bitu_op_e;
endpackage

// File: rtl/bitu_lead_one.sv
module bitu_lead_one #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] count
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] cnt;

  // Scanning upward lets the highest set bit win the last assignment.
  always_comb begin
    cnt = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (opnd[i]) cnt = CNT_W'(DATA_W - 1 - i);
    end
  end

  assign count = DATA_W'(cnt);
endmodule

// File: rtl/bitu_reverse.sv
module bitu_reverse #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] mirrored
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign mirrored[g] = opnd[DATA_W-1-g];
  end
endmodule

// File: rtl/bitu_byte_ops.sv
module bitu_byte_ops #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        ext_mode,
  output logic [DATA_W-1:0] lane_val,
  output logic [DATA_W-1:0] ext_val,
  output logic              all_nz
);
  localparam int LANES = DATA_W / 8;

  logic [7:0]       lane [LANES];
  logic [LANES-1:0] lane_nz;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g]    = opnd[8*g +: 8];
    assign lane_nz[g] = |opnd[8*g +: 8];
  end

  assign all_nz   = &lane_nz;
  assign lane_val = DATA_W'(lane[lane_sel]);

  // ext_mode: 0 zero byte, 1 sign byte, 2 zero half, 3 sign half
  always_comb begin
    unique case (ext_mode)
      2'd0:    ext_val = {{(DATA_W-8){1'b0}}, opnd[7:0]};
      2'd1:    ext_val = {{(DATA_W-8){opnd[7]}}, opnd[7:0]};
      2'd2:    ext_val = {{(DATA_W-16){1'b0}}, opnd[15:0]};
      default: ext_val = {{(DATA_W-16){opnd[15]}}, opnd[15:0]};
    endcase
  end
endmodule

// File: rtl/bitu_dec_cmp.sv
module bitu_dec_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] diff,
  output logic              neg,
  output logic              pos,
  output logic              nonzero
);
  assign diff    = opnd - DATA_W'(1);
  assign nonzero = |diff;
  assign neg     = diff[DATA_W-1];
  assign pos     = !diff[DATA_W-1] && nonzero;
endmodule

// File: rtl/bitu_unit.sv
module bitu_unit
  import bitu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic              in_carry,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res,
  output logic              out_dst_ext,
  output logic              out_cwe,
  output logic              out_carry
);
  bitu_op_e op;
  assign op = bitu_op_e'(in_op);

  logic [DATA_W-1:0] lead_cnt, mirrored, lane_val, ext_val, dec_val;
  logic              all_nz, dec_neg, dec_pos, dec_nz;

  bitu_lead_one #(.DATA_W(DATA_W)) u_lead (
    .opnd(in_opnd), .count(lead_cnt)
  );

  bitu_reverse #(.DATA_W(DATA_W)) u_rev (
    .opnd(in_opnd), .mirrored(mirrored)
  );

  bitu_byte_ops #(.DATA_W(DATA_W)) u_bytes (
    .opnd(in_opnd), .lane_sel(in_op[1:0]), .ext_mode(in_op[1:0]),
    .lane_val(lane_val), .ext_val(ext_val), .all_nz(all_nz)
  );

  bitu_dec_cmp #(.DATA_W(DATA_W)) u_dec (
    .opnd(in_opnd), .diff(dec_val), .neg(dec_neg), .pos(dec_pos),
    .nonzero(dec_nz)
  );

  logic [DATA_W-1:0] nxt_res;
  logic              nxt_ext, nxt_cwe, nxt_c;

  always_comb begin
    nxt_res = in_opnd;
    nxt_ext = 1'b0;
    nxt_cwe = 1'b0;
    nxt_c   = in_carry;
    unique case (op)
      OP_XB0, OP_XB1, OP_XB2, OP_XB3: begin
        nxt_res = lane_val;
        nxt_ext = 1'b1;
        nxt_cwe = 1'b1;
        nxt_c   = |in_opnd;
      end
      OP_ZXB, OP_SXB, OP_ZXH, OP_SXH: nxt_res = ext_val;
      OP_DECLT: begin
        nxt_res = dec_val; nxt_cwe = 1'b1; nxt_c = dec_neg;
      end
      OP_DECGT: begin
        nxt_res = dec_val; nxt_cwe = 1'b1; nxt_c = dec_pos;
      end
      OP_DECNE: begin
        nxt_res = dec_val; nxt_cwe = 1'b1; nxt_c = dec_nz;
      end
      OP_ALLNZ: begin
        nxt_cwe = 1'b1; nxt_c = all_nz;
      end
      OP_LEAD1: nxt_res = lead_cnt;
      OP_REV:   nxt_res = mirrored;
      OP_ABS:   nxt_res = in_opnd[DATA_W-1] ? (~in_opnd + DATA_W'(1)) : in_opnd;
      default:  nxt_res = ~in_opnd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_res     <= '0;
      out_dst_ext <= 1'b0;
      out_cwe     <= 1'b0;
      out_carry   <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res     <= nxt_res;
        out_dst_ext <= nxt_ext;
        out_cwe     <= nxt_cwe;
        out_carry   <= nxt_c;
      end else begin
        out_cwe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitu_unit_chk.sv
module bitu_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [3:0]        in_op,
  input logic [DATA_W-1:0] in_opnd,
  input logic              in_carry,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_res,
  input logic              out_dst_ext,
  input logic              out_cwe,
  input logic              out_carry
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld); // R10
  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (rst) !out_vld |-> !out_cwe); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(out_res)); // R10
  AST_EXT_ZERO_TOP: assert property (@(posedge clk) disable iff (rst) out_dst_ext |-> out_res[DATA_W-1:8] == '0); // R2
  AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (rst) in_vld && (in_op[3:2] == 2'b01 || in_op[3:2] == 2'b11) |=> !out_cwe && out_carry == $past(in_carry)); // R9
  AST_NOT_INV: assert property (@(posedge clk) disable iff (rst) in_vld && in_op == 4'hF |=> out_res == ~$past(in_opnd)); // R8
  AST_ALLNZ_SAME: assert property (@(posedge clk) disable iff (rst) in_vld && in_op == 4'h9 |=> out_res == $past(in_opnd) && out_cwe); // R5
endmodule

bind bitu_unit bitu_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bitu_unit_tb_top.sv
module bitu_unit_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [3:0]   in_op = '0;
  logic [W-1:0] in_opnd = '0;
  logic         in_carry = 1'b0;
  logic         out_vld, out_dst_ext, out_cwe, out_carry;
  logic [W-1:0] out_res;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitu_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
    .in_opnd(in_opnd), .in_carry(in_carry), .out_vld(out_vld),
    .out_res(out_res), .out_dst_ext(out_dst_ext), .out_cwe(out_cwe),
    .out_carry(out_carry)
  );

  function automatic string req_of(input logic [3:0] op);
    if (op <= 4'h3) return "R2";
    if (op <= 4'h7) return "R3";
    if (op == 4'h9) return "R5";
    if (op <= 4'hB) return "R4";
    if (op == 4'hC) return "R6";
    if (op == 4'hD) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [W+3:0] act, input logic [W+3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] v, input logic c);
    logic [W-1:0] e_res;
    logic e_ext, e_we, e_c, c_eff;
    logic [W-1:0] d;
    int lz;
    e_ext = 1'b0; e_we = 1'b0; e_c = c; e_res = v;
    d = v - 1;
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3: begin
        e_res = (v >> (8 * op)) & 32'hFF; e_ext = 1'b1; e_we = 1'b1; e_c = (v != 0);
      end
      4'h4: e_res = v & 32'hFF;
      4'h5: e_res = v[7] ? (v | 32'hFFFFFF00) : (v & 32'hFF);
      4'h6: e_res = v & 32'hFFFF;
      4'h7: e_res = v[15] ? (v | 32'hFFFF0000) : (v & 32'hFFFF);
      4'h8: begin e_res = d; e_we = 1'b1; e_c = ($signed(d) < 0); end
      4'h9: begin
        e_we = 1'b1;
        e_c = (v[31:24] != 0) && (v[23:16] != 0) && (v[15:8] != 0) && (v[7:0] != 0);
      end
      4'hA: begin e_res = d; e_we = 1'b1; e_c = ($signed(d) > 0); end
      4'hB: begin e_res = d; e_we = 1'b1; e_c = (d != 0); end
      4'hC: begin
        lz = 0;
        while (lz < 32 && !v[31-lz]) lz++;
        e_res = 32'(lz);
      end
      4'hD: for (int i = 0; i < 32; i++) e_res[i] = v[31-i];
      4'hE: e_res = v[31] ? (0 - v) : v;
      default: e_res = ~v;
    endcase
    c_eff = e_c;
    @(negedge clk);
    in_vld = 1'b1; in_op = op; in_opnd = v; in_carry = c;
    @(negedge clk);
    in_vld = 1'b0;
    check(req_of(op), {out_vld, out_dst_ext, out_cwe, out_carry, out_res},
          {1'b1, e_ext, e_we, c_eff, e_res});
    if (!e_we) check("R9", {3'b0, out_cwe, out_carry, 31'b0}, {3'b0, 1'b0, c, 31'b0});
    check("R1", {{(W+3){1'b0}}, out_dst_ext}, {{(W+3){1'b0}}, (op <= 4'h3)});
    @(negedge clk);
    check("R10", {1'b0, out_vld, out_cwe, 1'b0, out_res}, {1'b0, 1'b0, 1'b0, 1'b0, e_res});
  endtask

  initial begin
    logic [W-1:0] lfsr;
    logic [W-1:0] edges [16];
    edges = '{32'h0, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF,
              32'h1, 32'h2, 32'h00010000, 32'h40000000,
              32'h12345678, 32'hA1B2C3D4, 32'h01010100, 32'h00FFFFFF,
              32'h00008080, 32'h80000001, 32'hFF00FF00, 32'h01020304};
    repeat (3) @(negedge clk);
    // R11: outputs cleared under reset
    check("R11", {out_vld, out_dst_ext, out_cwe, out_carry, out_res}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", {out_vld, out_dst_ext, out_cwe, out_carry, out_res}, '0);
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 48; k++) begin
      logic [W-1:0] v;
      if (k < 16) v = edges[k];
      else begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        v = lfsr;
      end
      for (int op = 0; op < 16; op++) begin
        apply(4'(op), v, 1'b0);
        apply(4'(op), v, 1'b1);
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule